// File: doc/BRIEF.md
# Strided Two-Dimensional Block Mover

This engine copies rectangular regions between a 2 x 4 KiB on-chip local store (an instruction bank and a data bank) and a 16 MiB external DRAM space. Each step is one 64-bit word. Software first writes a local start address and a DRAM start address into two pending registers. A write to one of two shape registers then starts the copy. The first shape register copies DRAM into local memory and the second copies local memory into DRAM. The shape word gives a row length, a row count and a gap. The gap is added to the DRAM pointer after every row and never to the local pointer.

Both memory ports are plain synchronous ports with one cycle of read latency. The engine reads word k from the source while it writes word k-1 to the destination, so one word moves on every cycle. When the last word has landed, the engine loads the final pointers into the visible address registers and puts both shape registers back into their idle form. It then raises `done_o` for one cycle.

Top module: `tile_dma`

## Requirements
- R1: After reset, both visible address outputs read 0, both shape outputs read 0x00000FF8, and `busy_o` and `done_o` are low.
- R2: Register select 0 loads the pending local address and select 1 loads the pending DRAM address. Neither write starts a copy or changes any visible output.
- R3: When idle, a write with select 2 stores the word in the to-local shape register (`rd_len_o`) and starts a DRAM-to-local copy.
- R4: When idle, a write with select 3 stores the word in the to-DRAM shape register (`wr_len_o`) and starts a local-to-DRAM copy. In every cycle at most one of the two memory ports is writing.
- R5: Shape word fields: bits 11:3 + 1 give the words per row (bits 2:0 are ignored, so a value of 0 moves 8 bytes). Bits 19:12 + 1 give the row count.
- R6: Bits 31:23 give the gap in 8-byte words (bits 22:20 are ignored). After each row, including the last, the DRAM pointer moves by this gap in addition to its normal step. Words inside the gap are not touched, and the local pointer is never moved by the gap.
- R7: Local address bit 12 picks the bank (1 = instruction, driven as `lm_bank_o` = 1). Bits 11:3 give the start word. The local word index steps by one and wraps from 511 to 0 inside the same bank. The DRAM start word is address bits 23:3.
- R8: At completion, `local_addr_o` shows {original bank bit, final word offset, 3'b000} and `dram_addr_o` shows the final DRAM word pointer times 8.
- R9: At completion, each shape register keeps its own bits 31:23 and its bits 22:0 become 0x000FF8.
- R10: `busy_o` rises at the clock edge that accepts a start. It falls at the edge that commits the last destination write. A shape-register write made while busy is ignored and does not change either shape output.
- R11: For an N-word copy started at edge E0, `done_o` is high for exactly one cycle, the one after edge E0+N+1. The visible registers already hold their final values in that cycle, and `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 local addr, 1 DRAM addr, 2 to-local shape, 3 to-DRAM shape |
| reg_wdata_i | input | 32 | Register write data |
| local_addr_o | output | 32 | Visible local address register |
| dram_addr_o | output | 32 | Visible DRAM address register |
| rd_len_o | output | 32 | To-local shape register |
| wr_len_o | output | 32 | To-DRAM shape register |
| busy_o | output | 1 | Copy in progress |
| done_o | output | 1 | One-cycle completion pulse |
| lm_req_o | output | 1 | Local memory access request |
| lm_we_o | output | 1 | Local memory write enable |
| lm_bank_o | output | 1 | Local bank, 1 = instruction bank |
| lm_addr_o | output | 9 | Local word index inside the bank |
| lm_wdata_o | output | DATA_W | Local write data |
| lm_rdata_i | input | DATA_W | Local read data, valid one cycle after a read request |
| dr_req_o | output | 1 | DRAM access request |
| dr_we_o | output | 1 | DRAM write enable |
| dr_addr_o | output | DRAM_AW | DRAM word index |
| dr_wdata_o | output | DATA_W | DRAM write data |
| dr_rdata_i | input | DATA_W | DRAM read data, valid one cycle after a read request |

## Verification
The bench drives a start on a falling edge, so the accepting rising edge is E0. It then counts rising edges until `done_o` is seen on a falling edge, and for N words it expects the count N+2 (E0 plus N+1 further edges). `busy_o` must be high at the falling edge right after E0. `done_o` must be low again one edge later. The visible addresses and shape registers are read in the same done cycle, because the write-back and the done pulse come from the same edge. The write made while busy is checked one edge after it is sampled, and the memory images are compared only after done, when the last destination write has been committed.

// File: rtl/tdma_pkg.sv
package tdma_pkg;
  localparam int REG_W    = 32;
  localparam int LOCAL_AW = 9;   // 4 KiB bank / 8-byte words
  localparam int ROWS_W   = 8;

  localparam logic [REG_W-1:0] LEN_IDLE = 32'h0000_0FF8;
  localparam logic [REG_W-1:0] LEN_KEEP = 32'hFF80_0000;

  typedef enum logic [1:0] {
    SEL_LADDR    = 2'd0,
    SEL_DADDR    = 2'd1,
    SEL_TO_LOCAL = 2'd2,
    SEL_TO_DRAM  = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } state_e;

  typedef struct packed {
    logic [LOCAL_AW-1:0] row_words_m1;
    logic [ROWS_W-1:0]   rows_m1;
    logic [LOCAL_AW-1:0] gap_words;
  } shape_t;

  function automatic shape_t decode_shape(input logic [REG_W-1:0] w);
    shape_t s;
    s.row_words_m1 = w[11:3];
    s.rows_m1      = w[19:12];
    s.gap_words    = w[31:23];
    return s;
  endfunction
endpackage

// File: rtl/tdma_regs.sv
module tdma_regs import tdma_pkg::*; #(
  parameter int DRAM_AW = 21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          sel_i,
  input  logic [REG_W-1:0]    wdata_i,
  input  logic                busy_i,
  input  logic                fin_i,
  input  logic                fin_bank_i,
  input  logic [LOCAL_AW-1:0] fin_off_i,
  input  logic [DRAM_AW-1:0]  fin_dword_i,
  output logic                start_o,
  output logic                start_to_local_o,
  output shape_t              start_shape_o,
  output logic                pend_bank_o,
  output logic [LOCAL_AW-1:0] pend_off_o,
  output logic [DRAM_AW-1:0]  pend_dword_o,
  output logic [REG_W-1:0]    local_addr_o,
  output logic [REG_W-1:0]    dram_addr_o,
  output logic [REG_W-1:0]    rd_len_o,
  output logic [REG_W-1:0]    wr_len_o
);
  localparam int LPAD = REG_W - LOCAL_AW - 4;
  localparam int DPAD = REG_W - DRAM_AW - 3;

  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  logic [REG_W-1:0] rd_len_q, wr_len_q, laddr_q, daddr_q;

  assign start_o          = we_i && !busy_i && (sel == SEL_TO_LOCAL || sel == SEL_TO_DRAM);
  assign start_to_local_o = (sel == SEL_TO_LOCAL);
  assign start_shape_o    = decode_shape(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_bank_o  <= 1'b0;
      pend_off_o   <= '0;
      pend_dword_o <= '0;
      rd_len_q     <= LEN_IDLE;
      wr_len_q     <= LEN_IDLE;
      laddr_q      <= '0;
      daddr_q      <= '0;
    end else begin
      if (we_i && sel == SEL_LADDR) begin
        pend_bank_o <= wdata_i[LOCAL_AW+3];
        pend_off_o  <= wdata_i[LOCAL_AW+2:3];
      end
      if (we_i && sel == SEL_DADDR) pend_dword_o <= wdata_i[DRAM_AW+2:3];
      if (fin_i) begin
        rd_len_q <= (rd_len_q & LEN_KEEP) | LEN_IDLE;
        wr_len_q <= (wr_len_q & LEN_KEEP) | LEN_IDLE;
        laddr_q  <= {{LPAD{1'b0}}, fin_bank_i, fin_off_i, 3'b000};
        daddr_q  <= {{DPAD{1'b0}}, fin_dword_i, 3'b000};
      end else if (start_o) begin
        if (start_to_local_o) rd_len_q <= wdata_i;
        else                  wr_len_q <= wdata_i;
      end
    end
  end

  assign rd_len_o     = rd_len_q;
  assign wr_len_o     = wr_len_q;
  assign local_addr_o = laddr_q;
  assign dram_addr_o  = daddr_q;

  assert_ignore_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && busy_i && !fin_i && sel_i[1]) |=> ($stable(rd_len_o) && $stable(wr_len_o)));

  assert_len_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> (rd_len_o[22:0] == 23'h000FF8 && wr_len_o[22:0] == 23'h000FF8));
endmodule

// File: rtl/tdma_seq.sv
module tdma_seq import tdma_pkg::*; #(
  parameter int DRAM_AW = 21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                start_to_local_i,
  input  shape_t              shape_i,
  input  logic                pend_bank_i,
  input  logic [LOCAL_AW-1:0] pend_off_i,
  input  logic [DRAM_AW-1:0]  pend_dword_i,
  output logic                busy_o,
  output logic                issue_o,
  output logic                fin_o,
  output logic                to_local_o,
  output logic                bank_o,
  output logic [LOCAL_AW-1:0] local_ptr_o,
  output logic [DRAM_AW-1:0]  dram_ptr_o
);
  state_e              state_q;
  shape_t              shape_q;
  logic [LOCAL_AW-1:0] col_q;
  logic [ROWS_W-1:0]   row_q;
  logic                row_end, last;

  assign row_end = (col_q == shape_q.row_words_m1);
  assign last    = row_end && (row_q == shape_q.rows_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      shape_q     <= '0;
      col_q       <= '0;
      row_q       <= '0;
      to_local_o  <= 1'b0;
      bank_o      <= 1'b0;
      local_ptr_o <= '0;
      dram_ptr_o  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q     <= ST_RUN;
          shape_q     <= shape_i;
          col_q       <= '0;
          row_q       <= '0;
          to_local_o  <= start_to_local_i;
          bank_o      <= pend_bank_i;
          local_ptr_o <= pend_off_i;
          dram_ptr_o  <= pend_dword_i;
        end
        ST_RUN: begin
          local_ptr_o <= local_ptr_o + 1'b1;  // wraps inside the bank
          if (row_end) begin
            col_q      <= '0;
            row_q      <= row_q + 1'b1;
            dram_ptr_o <= dram_ptr_o + DRAM_AW'(1) + DRAM_AW'(shape_q.gap_words);
          end else begin
            col_q      <= col_q + 1'b1;
            dram_ptr_o <= dram_ptr_o + 1'b1;
          end
          if (last) state_q <= ST_DRAIN;
        end
        ST_DRAIN: state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != ST_IDLE);
  assign issue_o = (state_q == ST_RUN);
  assign fin_o   = (state_q == ST_DRAIN);

  assert_rows_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |-> (row_q <= shape_q.rows_m1 && col_q <= shape_q.row_words_m1));

  assert_bank_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN) |=> $stable(bank_o));
endmodule

// File: rtl/tile_dma.sv
module tile_dma import tdma_pkg::*; #(
  parameter int DATA_W  = 64,
  parameter int DRAM_AW = 21
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         local_addr_o,
  output logic [31:0]         dram_addr_o,
  output logic [31:0]         rd_len_o,
  output logic [31:0]         wr_len_o,
  output logic                busy_o,
  output logic                done_o,
  output logic                lm_req_o,
  output logic                lm_we_o,
  output logic                lm_bank_o,
  output logic [8:0]          lm_addr_o,
  output logic [DATA_W-1:0]   lm_wdata_o,
  input  logic [DATA_W-1:0]   lm_rdata_i,
  output logic                dr_req_o,
  output logic                dr_we_o,
  output logic [DRAM_AW-1:0]  dr_addr_o,
  output logic [DATA_W-1:0]   dr_wdata_o,
  input  logic [DATA_W-1:0]   dr_rdata_i
);
  logic                start, start_to_local, pend_bank;
  shape_t              start_shape;
  logic [LOCAL_AW-1:0] pend_off, local_ptr;
  logic [DRAM_AW-1:0]  pend_dword, dram_ptr;
  logic                busy, issue, fin, to_local, bank;

  tdma_regs #(.DRAM_AW(DRAM_AW)) u_regs (
    .clk_i, .rst_ni,
    .we_i            (reg_we_i),
    .sel_i           (reg_sel_i),
    .wdata_i         (reg_wdata_i),
    .busy_i          (busy),
    .fin_i           (fin),
    .fin_bank_i      (bank),
    .fin_off_i       (local_ptr),
    .fin_dword_i     (dram_ptr),
    .start_o         (start),
    .start_to_local_o(start_to_local),
    .start_shape_o   (start_shape),
    .pend_bank_o     (pend_bank),
    .pend_off_o      (pend_off),
    .pend_dword_o    (pend_dword),
    .local_addr_o,
    .dram_addr_o,
    .rd_len_o,
    .wr_len_o
  );

  tdma_seq #(.DRAM_AW(DRAM_AW)) u_seq (
    .clk_i, .rst_ni,
    .start_i         (start),
    .start_to_local_i(start_to_local),
    .shape_i         (start_shape),
    .pend_bank_i     (pend_bank),
    .pend_off_i      (pend_off),
    .pend_dword_i    (pend_dword),
    .busy_o          (busy),
    .issue_o         (issue),
    .fin_o           (fin),
    .to_local_o      (to_local),
    .bank_o          (bank),
    .local_ptr_o     (local_ptr),
    .dram_ptr_o      (dram_ptr)
  );

  // write stage: destination address trails the read by one cycle
  logic                wr_valid_q, done_q;
  logic [LOCAL_AW-1:0] wr_local_q;
  logic [DRAM_AW-1:0]  wr_dram_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_valid_q <= 1'b0;
      wr_local_q <= '0;
      wr_dram_q  <= '0;
      done_q     <= 1'b0;
    end else begin
      wr_valid_q <= issue;
      wr_local_q <= local_ptr;
      wr_dram_q  <= dram_ptr;
      done_q     <= fin;
    end
  end

  assign busy_o     = busy;
  assign done_o     = done_q;
  assign lm_bank_o  = bank;
  assign lm_req_o   = to_local ? wr_valid_q : issue;
  assign lm_we_o    = to_local && wr_valid_q;
  assign lm_addr_o  = to_local ? wr_local_q : local_ptr;
  assign lm_wdata_o = dr_rdata_i;
  assign dr_req_o   = to_local ? issue : wr_valid_q;
  assign dr_we_o    = !to_local && wr_valid_q;
  assign dr_addr_o  = to_local ? dram_ptr : wr_dram_q;
  assign dr_wdata_o = lm_rdata_i;

  assert_done_pulse_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_start_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_sel_i[1] && !busy_o) |=> busy_o);

  assert_one_writer_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(lm_we_o && dr_we_o));

  assert_local_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lm_we_o && $past(lm_we_o)) |-> (lm_addr_o == $past(lm_addr_o) + 1'b1 && $stable(lm_bank_o)));
endmodule

// File: tb/tile_dma_test.sv
`timescale 1ns/1ps
module tile_dma_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] local_addr, dram_addr, rd_len, wr_len;
  logic        busy, done;
  logic        lm_req, lm_we, lm_bank, dr_req, dr_we;
  logic [8:0]  lm_addr;
  logic [20:0] dr_addr;
  logic [63:0] lm_wdata, lm_rdata, dr_wdata, dr_rdata;

  int checks = 0;
  int errors = 0;
  logic fill = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tile_dma uut (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .local_addr_o(local_addr), .dram_addr_o(dram_addr),
    .rd_len_o(rd_len), .wr_len_o(wr_len),
    .busy_o(busy), .done_o(done),
    .lm_req_o(lm_req), .lm_we_o(lm_we), .lm_bank_o(lm_bank), .lm_addr_o(lm_addr),
    .lm_wdata_o(lm_wdata), .lm_rdata_i(lm_rdata),
    .dr_req_o(dr_req), .dr_we_o(dr_we), .dr_addr_o(dr_addr),
    .dr_wdata_o(dr_wdata), .dr_rdata_i(dr_rdata)
  );

  function automatic logic [63:0] lpat(input int i);
    return {32'h1A1A_0000, 32'(i)};
  endfunction
  function automatic logic [63:0] dpat(input int i);
    return {32'hD00D_0000, 32'(i)};
  endfunction

  logic [63:0] lmem [0:1023];  // index {bank, word}
  logic [63:0] dmem [0:4095];

  always @(posedge clk) begin
    if (fill) begin
      for (int i = 0; i < 1024; i++) lmem[i] <= lpat(i);
      for (int i = 0; i < 4096; i++) dmem[i] <= dpat(i);
    end else begin
      if (lm_req && lm_we)  lmem[{lm_bank, lm_addr}] <= lm_wdata;
      if (lm_req && !lm_we) lm_rdata <= lmem[{lm_bank, lm_addr}];
      if (dr_req && dr_we)  dmem[dr_addr[11:0]] <= dr_wdata;
      if (dr_req && !dr_we) dr_rdata <= dmem[dr_addr[11:0]];
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] sel, input logic [31:0] w);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = w;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  // start at edge E0, expect done seen after N+2 counted edges
  task automatic run_xfer(input logic [1:0] sel, input logic [31:0] w, input int words,
                          input bit poke, input logic [31:0] poke_exp);
    int cnt;
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = w;
    @(posedge clk); cnt = 1;
    @(negedge clk); reg_we = 1'b0;
    chk("R10 busy after start", 64'(busy), 64'd1);
    if (poke) begin
      reg_we = 1'b1; reg_sel = 2'd3; reg_wdata = 32'h0;
      @(posedge clk); cnt++;
      @(negedge clk); reg_we = 1'b0;
      chk("R10 write while busy ignored", 64'(wr_len), 64'(poke_exp));
      chk("R10 busy still high", 64'(busy), 64'd1);
    end
    while (!done && cnt < 2000) begin
      @(posedge clk); cnt++;
      @(negedge clk);
    end
    chk("R11 cycles to done", 64'(cnt), 64'(words + 2));
    chk("R10 busy low at done", 64'(busy), 64'd0);
    @(posedge clk); @(negedge clk);
    chk("R11 done one cycle", 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 local_addr", 64'(local_addr), 64'd0);
    chk("R1 dram_addr", 64'(dram_addr), 64'd0);
    chk("R1 rd_len", 64'(rd_len), 64'h0FF8);
    chk("R1 wr_len", 64'(wr_len), 64'h0FF8);
    chk("R1 busy", 64'(busy), 64'd0);
    chk("R1 done", 64'(done), 64'd0);
  endtask

  // R3 R5: single row, length low bits ignored, instruction bank
  task automatic t_to_local_row;
    reg_write(2'd0, 32'h0000_1040);
    reg_write(2'd1, 32'h0000_0100);
    chk("R2 local_addr unchanged", 64'(local_addr), 64'd0);
    chk("R2 dram_addr unchanged", 64'(dram_addr), 64'd0);
    chk("R2 no start", 64'(busy), 64'd0);
    run_xfer(2'd2, 32'h0000_0010, 3, 1'b0, 32'h0);
    for (int k = 0; k < 3; k++) chk("R3 local word", lmem[512 + 8 + k], dpat(32 + k));
    chk("R5 word past row untouched", lmem[512 + 11], lpat(512 + 11));
    chk("R7 data bank untouched", lmem[8], lpat(8));
    chk("R8 local_addr", 64'(local_addr), 64'h1058);
    chk("R8 dram_addr", 64'(dram_addr), 64'h118);
    chk("R9 rd_len idle", 64'(rd_len), 64'h0FF8);
  endtask

  // R4 R6: 3 rows of 2 words, gap 2 words, data bank
  task automatic t_to_dram_2d;
    reg_write(2'd0, 32'h0000_0020);
    reg_write(2'd1, 32'h0000_2000);
    run_xfer(2'd3, 32'h0100_2008, 6, 1'b0, 32'h0);
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 2; c++)
        chk("R4 dram word", dmem[1024 + r * 4 + c], lpat(4 + r * 2 + c));
    chk("R6 gap untouched", dmem[1024 + 2], dpat(1024 + 2));
    chk("R6 gap untouched", dmem[1024 + 7], dpat(1024 + 7));
    chk("R8 local_addr", 64'(local_addr), 64'h050);
    chk("R8 dram_addr", 64'(dram_addr), 64'h2060);
    chk("R9 wr_len keeps top", 64'(wr_len), 64'h0100_0FF8);
  endtask

  // R7: wrap inside bank 1
  task automatic t_wrap;
    reg_write(2'd0, 32'h0000_1FF0);
    reg_write(2'd1, 32'h0000_0200);
    run_xfer(2'd2, 32'h0000_0018, 4, 1'b0, 32'h0);
    chk("R7 word 510", lmem[512 + 510], dpat(64));
    chk("R7 word 511", lmem[512 + 511], dpat(65));
    chk("R7 wrap word 0", lmem[512 + 0], dpat(66));
    chk("R7 wrap word 1", lmem[512 + 1], dpat(67));
    chk("R7 other bank word 0", lmem[0], lpat(0));
    chk("R7 other bank word 1", lmem[1], lpat(1));
    chk("R8 local_addr wrapped", 64'(local_addr), 64'h1010);
    chk("R8 dram_addr", 64'(dram_addr), 64'h220);
  endtask

  // R9: upper bits kept per register
  task automatic t_keep_top;
    reg_write(2'd0, 32'h0000_0000);
    reg_write(2'd1, 32'h0000_0008);
    run_xfer(2'd2, 32'h7F80_0000, 1, 1'b0, 32'h0);
    chk("R5 one word for len 0", lmem[0], dpat(1));
    chk("R5 second word untouched", lmem[1], lpat(1));
    chk("R6 gap after last row", 64'(dram_addr), 64'h808);
    chk("R8 local_addr", 64'(local_addr), 64'h008);
    chk("R9 rd_len", 64'(rd_len), 64'h7F80_0FF8);
    chk("R9 wr_len", 64'(wr_len), 64'h0100_0FF8);
  endtask

  // R6 R10: gap low bits masked, write while busy ignored
  task automatic t_busy_gap;
    reg_write(2'd0, 32'h0000_1100);
    reg_write(2'd1, 32'h0000_0000);
    run_xfer(2'd2, 32'hFFF0_1001, 2, 1'b1, 32'h0100_0FF8);
    chk("R6 row 0", lmem[512 + 32], dpat(0));
    chk("R6 row 1 after gap", lmem[512 + 33], dpat(512));
    chk("R6 dram_addr", 64'(dram_addr), 64'h2000);
    chk("R8 local_addr", 64'(local_addr), 64'h1110);
    chk("R9 rd_len", 64'(rd_len), 64'hFF80_0FF8);
    chk("R10 wr_len after ignored write", 64'(wr_len), 64'h0100_0FF8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R10 no second copy", 64'(busy), 64'd0);
    chk("R4 dram not written", dmem[0], dpat(0));
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    fill = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    fill = 1'b0;
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_to_local_row();
    t_to_dram_2d();
    t_wrap();
    t_keep_top();
    t_busy_gap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule